// File: doc/BRIEF.md
# Message-Signalled Interrupt Capture Controller

This block sits behind the receive side of a PCIe root port and converts inbound memory-write messages into interrupt status. Software programs a 64-bit capture address through a 32-bit register bus. Whenever a message arrives whose address equals that capture address, the low bits of its data payload name one of 256 vectors. If that vector is enabled, its status bit is set. The vectors are packed into eight groups of 32. Each group has its own enable, mask and status registers.

A single interrupt output stays high while any status bit is set and its mask bit is clear. Software services the interrupt by reading the status registers and writing ones back to clear the bits it has handled. Messages reach the block as a one-cycle strobe that carries a 64-bit address and 32-bit data. The register bus is a one-cycle request with a write flag. Read data appears on the cycle after the request.

Top module: `msi_capture_ctrl`

## Requirements
- R1: After reset every register reads as zero and `irq_out` is low.
- R2: The capture address is split across two registers. Its low word is at byte offset 0x820 and its high word at 0x824, and both read back what was written.
- R3: Group g (0..7) has its enable register at 0x828 + 12·g, its mask register at 0x82C + 12·g and its status register at 0x830 + 12·g. Enable and mask read back what was written. Byte address bits [1:0] are ignored.
- R4: A message is a hit when `msg_valid` is high and all 64 address bits equal the capture address. On a hit, vector n = `msg_data[7:0]` selects group n/32 and bit n mod 32. If that enable bit is 1, the status bit reads as 1 from the next cycle. Data bits [31:8] have no effect.
- R5: A message whose address differs from the capture address in any bit, high word or low word, changes no status bit.
- R6: A hit on a vector whose enable bit is 0 changes no status bit. This includes a vector that was enabled earlier and then disabled.
- R7: A register write to a status register clears every bit written as 1 and leaves every bit written as 0 unchanged. It never sets a bit.
- R8: A masked vector still records status on a hit but does not raise `irq_out`. Clearing the mask bit while status is pending raises `irq_out` on the next cycle.
- R9: `irq_out` is high exactly while some status bit is 1 with its mask bit 0. It follows the status registers with no added latency.
- R10: If a hit on an enabled vector and a status write with a 1 in that same bit occur in the same cycle, the bit ends up set.
- R11: Reads return data one cycle after the request. Reads of any word outside 0x820..0x884 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_req | input | 1 | Register access request, one cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read request |
| msg_valid | input | 1 | Inbound memory-write message strobe |
| msg_addr | input | 64 | Message target address |
| msg_data | input | 32 | Message payload; bits [7:0] are the vector |
| irq_out | output | 1 | Combined pending interrupt |

## Verification
A corrupted enable or mask bit shows up at a single vector. Either a message to that vector leaves its status readback unchanged one cycle later, or `irq_out` takes the wrong level in that same cycle. A wrong group decode puts the set bit into a neighbouring group's status register, and the next status read exposes it. A stuck or leaking status bit keeps `irq_out` high after the clearing write. The interrupt line is checked in the cycle right after each message and each clear.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
  localparam int unsigned REG_AW      = 12;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned VEC_PER_GRP = 32;
  localparam int unsigned GRP_STRIDE  = 12;

  localparam logic [REG_AW-1:0] OFF_CAP_LO = 12'h820;
  localparam logic [REG_AW-1:0] OFF_CAP_HI = 12'h824;
  localparam logic [REG_AW-1:0] OFF_GRP0   = 12'h828;

  typedef enum logic [1:0] {
    FLD_EN   = 2'd0,
    FLD_MASK = 2'd1,
    FLD_STAT = 2'd2
  } grp_field_e;

  // Word index (byte offset >> 2) of one field of one group.
  function automatic logic [REG_AW-3:0] grp_word(int g, grp_field_e f);
    logic [REG_AW-1:0] off;
    off = OFF_GRP0 + REG_AW'(g * GRP_STRIDE) + REG_AW'(int'(f) * 4);
    return off[REG_AW-1:2];
  endfunction
endpackage

// File: rtl/msi_msg_decode.sv
module msi_msg_decode
  import msi_cap_pkg::*;
#(
  parameter int unsigned NGRP = 8,
  localparam int unsigned GW  = $clog2(NGRP),
  localparam int unsigned VW  = GW + $clog2(VEC_PER_GRP)
) (
  input  logic          msg_valid,
  input  logic [63:0]   msg_addr,
  input  logic [31:0]   msg_data,
  input  logic [63:0]   cap_addr,
  output logic          hit,
  output logic [GW-1:0] vec_grp,
  output logic [4:0]    vec_bit
);
  logic unused_data;
  assign unused_data = ^msg_data[31:VW];

  always_comb begin
    hit     = msg_valid && (msg_addr == cap_addr);
    vec_bit = msg_data[4:0];
    vec_grp = msg_data[VW-1:5];
  end
endmodule

// File: rtl/msi_vec_group.sv
module msi_vec_group
  import msi_cap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_mask,
  input  logic              wr_stat,
  input  logic [WORD_W-1:0] wdata,
  input  logic              set_req,
  input  logic [4:0]        set_bit,
  output logic [WORD_W-1:0] en_q,
  output logic [WORD_W-1:0] mask_q,
  output logic [WORD_W-1:0] stat_q,
  output logic              pend
);
  logic [WORD_W-1:0] set_vec, clr_vec, stat_d;
  logic              stat_ce;

  always_comb begin
    set_vec = set_req ? ((WORD_W'(1) << set_bit) & en_q) : '0;
    clr_vec = wr_stat ? wdata : '0;
    // new capture wins over a simultaneous clear of the same bit
    stat_d  = (stat_q & ~clr_vec) | set_vec;
    stat_ce = wr_stat | set_req;
    pend    = |(stat_q & ~mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      if (wr_en)   en_q   <= wdata;
      if (wr_mask) mask_q <= wdata;
      if (stat_ce) stat_q <= stat_d;
    end
  end
endmodule

// File: rtl/msi_reg_if.sv
module msi_reg_if
  import msi_cap_pkg::*;
#(
  parameter int unsigned NGRP = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_req,
  input  logic                        reg_we,
  input  logic [REG_AW-1:0]           reg_addr,
  input  logic [WORD_W-1:0]           reg_wdata,
  input  logic [NGRP-1:0][WORD_W-1:0] en_g,
  input  logic [NGRP-1:0][WORD_W-1:0] mask_g,
  input  logic [NGRP-1:0][WORD_W-1:0] stat_g,
  output logic [63:0]                 cap_addr,
  output logic [NGRP-1:0]             wr_en,
  output logic [NGRP-1:0]             wr_mask,
  output logic [NGRP-1:0]             wr_stat,
  output logic [WORD_W-1:0]           reg_rdata
);
  logic [REG_AW-3:0] word;
  logic              do_wr, do_rd, wr_lo, wr_hi;
  logic [WORD_W-1:0] cap_lo_q, cap_hi_q, rd_d, rd_q;
  logic unused_addr;

  assign unused_addr = ^reg_addr[1:0];

  always_comb begin
    word    = reg_addr[REG_AW-1:2];
    do_wr   = reg_req && reg_we;
    do_rd   = reg_req && !reg_we;
    wr_lo   = do_wr && (word == OFF_CAP_LO[REG_AW-1:2]);
    wr_hi   = do_wr && (word == OFF_CAP_HI[REG_AW-1:2]);
    wr_en   = '0;
    wr_mask = '0;
    wr_stat = '0;
    rd_d    = '0;
    if (word == OFF_CAP_LO[REG_AW-1:2]) rd_d = cap_lo_q;
    if (word == OFF_CAP_HI[REG_AW-1:2]) rd_d = cap_hi_q;
    for (int g = 0; g < NGRP; g++) begin
      if (word == grp_word(g, FLD_EN)) begin
        wr_en[g] = do_wr;
        rd_d     = en_g[g];
      end
      if (word == grp_word(g, FLD_MASK)) begin
        wr_mask[g] = do_wr;
        rd_d       = mask_g[g];
      end
      if (word == grp_word(g, FLD_STAT)) begin
        wr_stat[g] = do_wr;
        rd_d       = stat_g[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_lo_q <= '0;
      cap_hi_q <= '0;
      rd_q     <= '0;
    end else begin
      if (wr_lo) cap_lo_q <= reg_wdata;
      if (wr_hi) cap_hi_q <= reg_wdata;
      if (do_rd) rd_q     <= rd_d;
    end
  end

  assign cap_addr  = {cap_hi_q, cap_lo_q};
  assign reg_rdata = rd_q;
endmodule

// File: rtl/msi_capture_ctrl.sv
module msi_capture_ctrl
  import msi_cap_pkg::*;
#(
  parameter int unsigned NGRP = 8,
  localparam int unsigned GW  = $clog2(NGRP),
  localparam int unsigned NVEC = NGRP * VEC_PER_GRP
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_req,
  input  logic        reg_we,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        msg_valid,
  input  logic [63:0] msg_addr,
  input  logic [31:0] msg_data,
  output logic        irq_out
);
  logic [NGRP-1:0][WORD_W-1:0] en_g, mask_g, stat_g;
  logic [NGRP-1:0]             wr_en, wr_mask, wr_stat, pend;
  logic [63:0]                 cap_addr;
  logic                        hit;
  logic [GW-1:0]               vec_grp;
  logic [4:0]                  vec_bit;
  logic [NVEC-1:0]             en_all, mask_all, stat_all;

  msi_reg_if #(.NGRP(NGRP)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .en_g(en_g), .mask_g(mask_g), .stat_g(stat_g),
    .cap_addr(cap_addr), .wr_en(wr_en), .wr_mask(wr_mask), .wr_stat(wr_stat),
    .reg_rdata(reg_rdata)
  );

  msi_msg_decode #(.NGRP(NGRP)) dec_i (
    .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data),
    .cap_addr(cap_addr), .hit(hit), .vec_grp(vec_grp), .vec_bit(vec_bit)
  );

  for (genvar g = 0; g < NGRP; g++) begin : gen_grp
    msi_vec_group grp_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en[g]), .wr_mask(wr_mask[g]), .wr_stat(wr_stat[g]),
      .wdata(reg_wdata),
      .set_req(hit && (vec_grp == GW'(g))), .set_bit(vec_bit),
      .en_q(en_g[g]), .mask_q(mask_g[g]), .stat_q(stat_g[g]), .pend(pend[g])
    );
  end

  assign en_all   = en_g;
  assign mask_all = mask_g;
  assign stat_all = stat_g;
  assign irq_out  = |pend;
endmodule

// File: rtl/msi_capture_chk.sv
module msi_capture_chk #(
  parameter int unsigned NGRP = 8,
  localparam int unsigned NVEC = NGRP * 32,
  localparam int unsigned VW   = $clog2(NVEC),
  localparam int unsigned TOPW = (12'h828 + NGRP * 12) >> 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_req,
  input logic            reg_we,
  input logic [11:0]     reg_addr,
  input logic [31:0]     reg_wdata,
  input logic [31:0]     reg_rdata,
  input logic            msg_valid,
  input logic [63:0]     msg_addr,
  input logic [31:0]     msg_data,
  input logic            irq_out,
  input logic [63:0]     cap_addr,
  input logic [NVEC-1:0] en_all,
  input logic [NVEC-1:0] mask_all,
  input logic [NVEC-1:0] stat_all
);
  logic [VW-1:0] v;
  logic          hit, any_wr, unmapped;

  always_comb begin
    v        = msg_data[VW-1:0];
    hit      = msg_valid && (msg_addr == cap_addr);
    any_wr   = reg_req && reg_we;
    unmapped = (reg_addr[11:2] < 10'h208) || (int'(reg_addr[11:2]) >= TOPW);
  end

  assert_capture_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit && en_all[v] && !any_wr |=> stat_all[$past(v)]);

  assert_capture_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hit && en_all[v] && !mask_all[v] && !any_wr |=> irq_out);

  assert_mismatch_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && (msg_addr != cap_addr) && !any_wr |=> $stable(stat_all));

  assert_disabled_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !en_all[v] && !any_wr |=> $stable(stat_all));

  assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
    any_wr && (reg_addr[11:2] == 10'h20C) && !msg_valid
      |=> (stat_all[31:0] & $past(reg_wdata)) == 32'h0);

  assert_quiet_when_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_all & ~mask_all) == '0) |-> !irq_out);

  assert_capture_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hit && en_all[v] && any_wr |=> stat_all[$past(v)]);

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && !reg_we && unmapped |=> reg_rdata == 32'h0);
endmodule

bind msi_capture_ctrl msi_capture_chk #(.NGRP(NGRP)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data),
  .irq_out(irq_out), .cap_addr(cap_addr),
  .en_all(en_all), .mask_all(mask_all), .stat_all(stat_all)
);

// File: tb/msi_capture_ctrl_tb.sv
`timescale 1ns/1ps
module msi_capture_ctrl_tb_top;
  logic        clk, rst_n;
  logic        reg_req, reg_we;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        msg_valid;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;
  logic        irq_out;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  logic [31:0] m_en[8], m_mask[8], m_stat[8];
  logic [63:0] m_cap;

  msi_capture_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data),
    .irq_out(irq_out)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_rd(logic [11:0] a);
    int w = int'(a[11:2]);
    if (w == 12'h820 >> 2) return m_cap[31:0];
    if (w == 12'h824 >> 2) return m_cap[63:32];
    for (int g = 0; g < 8; g++) begin
      if (w == (12'h828 + 12*g) >> 2) return m_en[g];
      if (w == (12'h82C + 12*g) >> 2) return m_mask[g];
      if (w == (12'h830 + 12*g) >> 2) return m_stat[g];
    end
    return 32'h0;
  endfunction

  function automatic logic model_irq();
    for (int g = 0; g < 8; g++) if ((m_stat[g] & ~m_mask[g]) != 0) return 1'b1;
    return 1'b0;
  endfunction

  // model effects of one cycle: register write first, then the message
  task automatic model_cycle(bit wr, logic [11:0] a, logic [31:0] d,
                             bit mv, logic [63:0] ma, logic [31:0] md);
    int w = int'(a[11:2]);
    if (wr) begin
      if (w == 12'h820 >> 2) m_cap[31:0]  = d;
      if (w == 12'h824 >> 2) m_cap[63:32] = d;
      for (int g = 0; g < 8; g++) begin
        if (w == (12'h828 + 12*g) >> 2) m_en[g]   = d;
        if (w == (12'h82C + 12*g) >> 2) m_mask[g] = d;
        if (w == (12'h830 + 12*g) >> 2) m_stat[g] = m_stat[g] & ~d;
      end
    end
    if (mv && ma == m_cap) begin
      int n = int'(md[7:0]);
      if (m_en[n/32][n%32]) m_stat[n/32][n%32] = 1'b1;
    end
  endtask

  // called at a negedge; drives one cycle and returns at the next negedge
  task automatic drive(bit rq, bit we, logic [11:0] a, logic [31:0] d,
                       bit mv, logic [63:0] ma, logic [31:0] md);
    reg_req = rq; reg_we = we; reg_addr = a; reg_wdata = d;
    msg_valid = mv; msg_addr = ma; msg_data = md;
    @(negedge clk);
    reg_req = 0; reg_we = 0; msg_valid = 0;
    model_cycle(rq && we, a, d, mv, ma, md);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    drive(1, 1, a, d, 0, 64'h0, 32'h0);
  endtask

  task automatic msg(logic [63:0] ma, logic [31:0] md);
    drive(0, 0, 12'h0, 32'h0, 1, ma, md);
  endtask

  task automatic rd(logic [11:0] a, string tag);
    exp_q.push_back(model_rd(a));
    tag_q.push_back($sformatf("%s rd@%h", tag, a));
    drive(1, 0, a, 32'h0, 0, 64'h0, 32'h0);
  endtask

  task automatic chk_irq(string tag);
    check(irq_out == model_irq(), {tag, " irq_out"}, 32'(irq_out), 32'(model_irq()));
  endtask

  // scoreboard monitor
  initial forever begin
    @(posedge clk);
    if (rst_n && reg_req && !reg_we) begin
      logic [31:0] e;
      string t;
      @(negedge clk);
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(reg_rdata == e, t, reg_rdata, e);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog all-reqs actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  localparam logic [63:0] CAP = 64'h0000_0001_FEE0_1000;

  initial begin
    for (int g = 0; g < 8; g++) begin m_en[g] = 0; m_mask[g] = 0; m_stat[g] = 0; end
    m_cap = 0;
    rst_n = 0; reg_req = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    msg_valid = 0; msg_addr = 0; msg_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk_irq("R1");
    rd(12'h820, "R1"); rd(12'h824, "R1"); rd(12'h828, "R1");
    rd(12'h82C, "R1"); rd(12'h830, "R1"); rd(12'h884, "R1");

    // R2 capture address
    wr(12'h820, CAP[31:0]); wr(12'h824, CAP[63:32]);
    rd(12'h820, "R2"); rd(12'h824, "R2");

    // R3 group register map, low address bits ignored
    wr(12'h828, 32'h0000_0021);
    wr(12'h87C, 32'h8000_0000);
    wr(12'h84D, 32'hFFFF_FFFF);
    rd(12'h828, "R3"); rd(12'h87C, "R3"); rd(12'h84C, "R3"); rd(12'h858, "R3");

    // R4 / R9 capture sets status and raises interrupt
    msg(CAP, 32'h0000_0005); chk_irq("R9");
    rd(12'h830, "R4");
    msg(CAP, 32'hABCD_01FF);        // vector 255, upper data bits ignored
    rd(12'h884, "R4"); rd(12'h830, "R4");

    // R5 address mismatch in either half
    msg({32'h2, CAP[31:0]}, 32'h0);
    msg({CAP[63:32], 32'hFEE0_1004}, 32'h0);
    rd(12'h830, "R5");

    // R6 disabled vector
    msg(CAP, 32'h1); rd(12'h830, "R6");

    // R7 write-one-to-clear
    wr(12'h830, 32'h0000_0001); rd(12'h830, "R7");
    wr(12'h830, 32'h0000_0020); rd(12'h830, "R7");
    chk_irq("R9");
    wr(12'h884, 32'h8000_0000); rd(12'h884, "R7");
    chk_irq("R9");

    // R8 masked vector records status silently
    wr(12'h850, 32'h0000_0004);
    msg(CAP, 32'd98); chk_irq("R8");
    rd(12'h854, "R8");
    wr(12'h850, 32'h0); chk_irq("R8");

    // R10 capture wins over simultaneous clear
    drive(1, 1, 12'h854, 32'h0000_0004, 1, CAP, 32'd98);
    rd(12'h854, "R10"); chk_irq("R10");
    wr(12'h854, 32'hFFFF_FFFF); rd(12'h854, "R7"); chk_irq("R9");

    // R6 after disabling via read-modify-write
    wr(12'h828, 32'h0000_0020);
    msg(CAP, 32'h0); rd(12'h830, "R6"); chk_irq("R6");

    // R11 unmapped reads
    rd(12'h000, "R11"); rd(12'h81C, "R11"); rd(12'h888, "R11"); rd(12'hFFC, "R11");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "scoreboard drained", 32'(exp_q.size()), 32'h0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule